// File: doc/BRIEF.md
# Successive approximation conversion controller

This block controls a 12-bit successive approximation conversion. A decoded bus command starts it. It puts the track-and-hold into hold, enables the bit clock and clears the approximation register. It then tests one bit per clock, from the most significant bit down. The bit under test is driven to an external DAC on `trial_o`. The comparator's verdict returns on `cmp_i`. A short conversion tests only the top eight bits.

When the last bit is decided, the bit clock stops and the track-and-hold returns to sample. The busy flag stays high for a further acquisition interval. Bus commands are ignored while the block is busy. Reads are the one exception: they are honoured during the acquisition interval, but never while bits are being tested. A read returns the result as one 12-bit word or as two bytes.

Top module: `sar_conv_ctrl`

## Requirements
- R1: With `en_i`=1, `sel_ni`=0 and `rd_nconv_i`=0 while not busy, the next clock raises `busy_o`, `hold_o` and `bit_clk_en_o`.
- R2: When `en_i`=0 or `sel_ni`=1, no conversion starts and `data_oe_o` stays 0, whatever the other inputs are.
- R3: A start clears the approximation register, so the first trial code on `trial_o` has only bit 11 set.
- R4: Bits are tested from bit 11 down to bit 0. A tested bit stays 1 when `cmp_i`=1 (trial sum not above the input) and is cleared when `cmp_i`=0.
- R5: A start with `addr0_i`=1 runs a short conversion. It tests bits 11 to 4 only, leaves result bits 3..0 at zero, and keeps `busy_o` high for 8+ACQ_CYCLES cycles.
- R6: While `hold_o` is high, `data_oe_o` is 0. While `busy_o` is high, start commands have no effect: the result and the busy length are unchanged.
- R7: After the last trial, `hold_o` and `bit_clk_en_o` fall. `busy_o` stays high for ACQ_CYCLES more cycles, so a full conversion is busy for 12+ACQ_CYCLES cycles.
- R8: A read command during the acquisition interval drives the result.
- R9: A read (`rd_nconv_i`=1) with `wide_i`=1 drives all 12 result bits on `data_o` with `data_oe_o`=1.
- R10: A read with `wide_i`=0 drives a byte on `data_o[7:0]` and zero on `data_o[11:8]`. With `addr0_i`=0 the byte is result bits 11..4. With `addr0_i`=1 the byte is result bits 3..0 followed by four zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Chip enable, active high |
| sel_ni | input | 1 | Chip select, active low |
| rd_nconv_i | input | 1 | 1 = read, 0 = convert |
| wide_i | input | 1 | Read width: 1 = word, 0 = byte |
| addr0_i | input | 1 | Convert: short conversion when 1. Byte read: low byte when 1 |
| cmp_i | input | 1 | Comparator: 1 = trial sum not above the input |
| trial_o | output | 12 | Trial code sent to the DAC |
| hold_o | output | 1 | Track-and-hold in hold |
| bit_clk_en_o | output | 1 | Bit clock enable |
| busy_o | output | 1 | Status: conversion or acquisition in progress |
| data_o | output | 12 | Read data |
| data_oe_o | output | 1 | Read data valid, output enable |

## Verification
The bench models the comparator as an ideal one: `trial_o` no greater than a chosen input value. A correct full conversion therefore returns that value exactly.

The input values are chosen to separate different errors:
- All zeros and all ones expose a stuck keep-or-drop decision.
- Alternating patterns expose a bit-order or index error.
- A value with low bits set, run as a short conversion, shows whether the conversion stopped at bit 4 and left the low bits at zero.

A further run injects a start command and a read while bits are being tested. It shows whether the block aborted or restarted the conversion, or leaked the output enable during the conversion. A read issued after `hold_o` falls separates acquisition-time reads from reads after `busy_o` falls.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_ACQ} sar_state_e;
  typedef enum logic [1:0] {RD_WORD, RD_HIGH, RD_LOW} rd_mode_e;
  typedef struct packed {
    logic     start;
    logic     short_c;
    logic     rd;
    rd_mode_e mode;
  } sar_cmd_t;
endpackage

// File: rtl/sar_cmd_decode.sv
module sar_cmd_decode
  import sar_pkg::*;
(
  input  logic     en_i,
  input  logic     sel_ni,
  input  logic     rd_nconv_i,
  input  logic     wide_i,
  input  logic     addr0_i,
  output sar_cmd_t cmd_o
);
  logic act;
  assign act = en_i & ~sel_ni;

  always_comb begin
    cmd_o.start   = act & ~rd_nconv_i;
    cmd_o.short_c = addr0_i;
    cmd_o.rd      = act & rd_nconv_i;
    if (wide_i)       cmd_o.mode = RD_WORD;
    else if (addr0_i) cmd_o.mode = RD_LOW;
    else              cmd_o.mode = RD_HIGH;
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned RES_W      = 12,
  parameter int unsigned SHORT_W    = 8,
  parameter int unsigned ACQ_CYCLES = 4,
  localparam int unsigned IDX_W     = $clog2(RES_W),
  localparam int unsigned ACQ_W     = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES + 1) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             short_i,
  output sar_state_e       state_o,
  output logic             clr_o,
  output logic             step_o,
  output logic [IDX_W-1:0] idx_o
);
  sar_state_e       state_q;
  logic [IDX_W-1:0] idx_q, stop_q;
  logic [ACQ_W-1:0] acq_q;
  logic             go, last;

  assign go     = start_i && (state_q == ST_IDLE);
  assign last   = (idx_q == stop_q);
  assign clr_o  = go;
  assign step_o = (state_q == ST_CONV);
  assign idx_o  = idx_q;
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      stop_q  <= '0;
      acq_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_CONV;
          idx_q   <= IDX_W'(RES_W - 1);
          stop_q  <= short_i ? IDX_W'(RES_W - SHORT_W) : '0;
        end
        ST_CONV: begin
          if (last) begin
            acq_q <= ACQ_W'(ACQ_CYCLES);
            state_q <= (ACQ_CYCLES == 0) ? ST_IDLE : ST_ACQ;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        ST_ACQ: begin
          acq_q <= acq_q - 1'b1;
          if (acq_q <= ACQ_W'(1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int unsigned RES_W  = 12,
  localparam int unsigned IDX_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o
);
  logic [RES_W-1:0] sar_q, bit_mask;

  assign bit_mask = step_i ? (RES_W'(1) << idx_i) : '0;
  assign trial_o  = sar_q | bit_mask;
  assign result_o = sar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sar_q <= '0;
    else if (clr_i)  sar_q <= '0;
    else if (step_i) sar_q[idx_i] <= cmp_i;
  end
endmodule

// File: rtl/sar_read_mux.sv
module sar_read_mux
  import sar_pkg::*;
#(
  parameter int unsigned RES_W  = 12,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LOW_W = RES_W - BYTE_W
) (
  input  logic [RES_W-1:0] result_i,
  input  rd_mode_e         mode_i,
  output logic [RES_W-1:0] data_o
);
  logic [BYTE_W-1:0] hi_byte, lo_byte;

  assign hi_byte = result_i[RES_W-1:LOW_W];
  generate
    if (LOW_W < BYTE_W) begin : g_pad
      assign lo_byte = {result_i[LOW_W-1:0], {(BYTE_W-LOW_W){1'b0}}};
    end else begin : g_nopad
      assign lo_byte = result_i[BYTE_W-1:0];
    end
  endgenerate

  always_comb begin
    case (mode_i)
      RD_HIGH: data_o = RES_W'(hi_byte);
      RD_LOW:  data_o = RES_W'(lo_byte);
      default: data_o = result_i;
    endcase
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned RES_W      = 12,
  parameter int unsigned SHORT_W    = 8,
  parameter int unsigned ACQ_CYCLES = 4,
  localparam int unsigned IDX_W     = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sel_ni,
  input  logic             rd_nconv_i,
  input  logic             wide_i,
  input  logic             addr0_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             hold_o,
  output logic             bit_clk_en_o,
  output logic             busy_o,
  output logic [RES_W-1:0] data_o,
  output logic             data_oe_o
);
  sar_cmd_t         cmd;
  sar_state_e       state;
  logic             clr, step;
  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] result, rd_data;

  sar_cmd_decode i_dec (
    .en_i, .sel_ni, .rd_nconv_i, .wide_i, .addr0_i, .cmd_o(cmd)
  );

  sar_seq #(.RES_W(RES_W), .SHORT_W(SHORT_W), .ACQ_CYCLES(ACQ_CYCLES)) i_seq (
    .clk_i, .rst_ni, .start_i(cmd.start), .short_i(cmd.short_c),
    .state_o(state), .clr_o(clr), .step_o(step), .idx_o(idx)
  );

  sar_approx_reg #(.RES_W(RES_W)) i_sar (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(step), .idx_i(idx), .cmp_i,
    .trial_o, .result_o(result)
  );

  sar_read_mux #(.RES_W(RES_W)) i_mux (
    .result_i(result), .mode_i(cmd.mode), .data_o(rd_data)
  );

  assign hold_o       = (state == ST_CONV);
  assign bit_clk_en_o = (state == ST_CONV);
  assign busy_o       = (state != ST_IDLE);
  assign data_oe_o    = cmd.rd && (state != ST_CONV);
  assign data_o       = data_oe_o ? rd_data : '0;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int unsigned RES_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             sel_ni,
  input logic             rd_nconv_i,
  input logic [RES_W-1:0] trial_o,
  input logic             hold_o,
  input logic             bit_clk_en_o,
  input logic             busy_o,
  input logic             data_oe_o
);
  // R1
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && en_i && !sel_ni && !rd_nconv_i) |=> (busy_o && hold_o && bit_clk_en_o));

  // R2
  desel_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || sel_ni) |-> !data_oe_o);

  // R2
  desel_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (!en_i || sel_ni)) |=> !busy_o);

  // R3
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> (trial_o == {1'b1, {(RES_W-1){1'b0}}}));

  // R6
  conv_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !data_oe_o);

  // R7
  acq_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> (busy_o && !bit_clk_en_o));

  // R8
  acq_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !hold_o && en_i && !sel_ni && rd_nconv_i) |-> data_oe_o);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_W(RES_W)) i_chk (.*);

// File: tb/test_sar_conv_ctrl.sv
`timescale 1ns/1ps
module test_sar_conv_ctrl;
  localparam int RW  = 12;
  localparam int ACQ = 4;

  logic clk = 0, rst_n = 0;
  logic en, sel_n, rd_nconv, wide, a0, cmp;
  logic [RW-1:0] trial, data, vin;
  logic hold, bclk, busy, oe;
  int checks = 0, errors = 0;
  logic [RW-1:0] exp_q[$];

  always #2.5 clk = ~clk;
  assign cmp = (trial <= vin);

  sar_conv_ctrl #(.ACQ_CYCLES(ACQ)) i_sar_conv_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sel_ni(sel_n), .rd_nconv_i(rd_nconv),
    .wide_i(wide), .addr0_i(a0), .cmp_i(cmp), .trial_o(trial), .hold_o(hold),
    .bit_clk_en_o(bclk), .busy_o(busy), .data_o(data), .data_oe_o(oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    en = 1; sel_n = 1; rd_nconv = 0; wide = 0; a0 = 0;
  endtask

  // monitor: compares every driven read with the scoreboard
  always begin
    @(negedge clk); #1;
    if (rst_n && oe) begin
      if (exp_q.size() == 0) chk("R6 unexpected oe", 1, 0);
      else chk("R9/R10 read data", data, exp_q.pop_front());
    end
  end

  function automatic logic [RW-1:0] rd_exp(logic [RW-1:0] r, logic w, logic a);
    if (w) return r;
    if (!a) return {4'h0, r[11:4]};
    return {4'h0, r[3:0], 4'h0};
  endfunction

  // drive one read cycle and push the expected bus value
  task automatic do_read(input logic [RW-1:0] res, input logic w, input logic a);
    @(negedge clk);
    en = 1; sel_n = 0; rd_nconv = 1; wide = w; a0 = a;
    exp_q.push_back(rd_exp(res, w, a));
    @(negedge clk); idle_bus();
  endtask

  task automatic convert(input logic [RW-1:0] v, input logic sh, input bit meddle,
                         input bit acq_rd);
    int cnt, hcnt, trials;
    bit rd_done;
    logic [RW-1:0] res;
    trials = sh ? 8 : 12;
    res = sh ? (v & 12'hFF0) : v;
    vin = v;
    @(negedge clk);
    en = 1; sel_n = 0; rd_nconv = 0; a0 = sh;
    @(posedge clk); #1;
    chk("R1 busy after start", busy, 1);
    chk("R1 hold after start", hold, 1);
    chk("R1 bit clock on", bclk, 1);
    chk("R3 first trial MSB only", trial, 12'h800);
    @(negedge clk); idle_bus();
    cnt = 1; hcnt = 1; rd_done = 0;
    forever begin
      @(negedge clk);
      idle_bus();
      if (meddle && cnt == 3) begin sel_n = 0; rd_nconv = 0; a0 = ~sh; end
      if (meddle && cnt == 4) begin sel_n = 0; rd_nconv = 1; wide = 1; end
      if (acq_rd && !rd_done && busy && !hold) begin
        sel_n = 0; rd_nconv = 1; wide = 1;
        exp_q.push_back(res);
        rd_done = 1;
      end
      #1;
      if (meddle && cnt == 4) chk("R6 oe low in conversion", oe, 0);
      if (!busy) break;
      cnt++;
      if (hold) hcnt++;
      if (!hold) chk("R7 bit clock off after trials", bclk, 0);
    end
    chk(sh ? "R5 short busy length" : "R7 busy length", cnt, trials + ACQ);
    chk(sh ? "R5 short trial count" : "R4 trial count", hcnt, trials);
    if (acq_rd) chk("R8 read issued in acquisition", rd_done, 1);
    do_read(res, 1, 0);
    do_read(res, 0, 0);
    do_read(res, 0, 1);
  endtask

  initial begin
    idle_bus(); vin = 0;
    #1;
    chk("R1 reset busy", busy, 0);
    chk("R1 reset hold", hold, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R2 reset oe", oe, 0);

    // R2: deselected convert and read do nothing
    @(negedge clk); en = 0; sel_n = 0; rd_nconv = 0;
    #1; chk("R2 en low no oe", oe, 0);
    @(negedge clk); idle_bus(); #1; chk("R2 en low no start", busy, 0);
    @(negedge clk); en = 1; sel_n = 1; rd_nconv = 1; wide = 1;
    #1; chk("R2 sel high no oe", oe, 0);
    @(negedge clk); en = 1; sel_n = 1; rd_nconv = 0;
    @(negedge clk); idle_bus(); #1; chk("R2 sel high no start", busy, 0);

    // R4 patterns for bit order and keep/drop
    convert(12'h000, 0, 0, 0);
    convert(12'hFFF, 0, 0, 0);
    convert(12'hA5A, 0, 0, 0);
    convert(12'h5A5, 0, 0, 1);   // R8
    convert(12'h3C7, 1, 0, 0);   // R5
    convert(12'h801, 0, 1, 0);   // R6 interference
    convert(12'h6B9, 1, 1, 1);
    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule